// File: doc/BRIEF.md
# Configurable Serial Flash Master

This block is a single-lane serial master for flash devices. It sits behind a four-word register window. One word sets up the link and the frame shape. One word holds an 8-bit mode value and a 24-bit dummy pattern. One word takes the transmit bytes when written and returns the received bytes when read. The last word starts a transfer when written and reports activity when read. A transfer sends a command byte first, then 0 to 24 dummy bits taken from the dummy pattern, then 0 to 4 data bytes. MISO is sampled during the data bytes only. Chip select is active low and SCLK is derived from the system clock.

At run time software chooses the idle level of SCLK, the SCLK edge on which MISO is captured, and the bit order. It can also delay capture by half an SCLK period. A further option takes one early input sample ahead of the first data bit. That early sample is taken only when the clock idle level equals the capture-edge setting and the option has not been switched off. Software loads the registers, writes the start word and polls the activity bit. When the bit reads 0 it reads the received word.

Top module: `spi_flash_master`

## Requirements
- R1: After reset, word 0 reads 0x00000004, word 1 reads 0, word 3 reads 0, cs_n is 1, and sclk and mosi are 0.
- R2: Word 3 bit 0 (busy) reads 1 from the clock edge that accepts a start until the edge that releases cs_n. It reads 0 from that edge on.
- R3: A write to word 3 with bit 8 set starts a transfer using command byte bits 7:0, but only if busy is 0. While busy is 1, a start and every other register write are ignored and the transfer runs unchanged.
- R4: Word 0 bit 2 selects MSB-first (1) or LSB-first (0) order. The choice applies to the command, dummy and data bits.
- R5: The frame is the command byte, then D dummy bits, then N data bytes. D is word 0 bits 12:8, and values above 24 act as 24. The dummy bits come from word 1 bits 23:0 (bit D-1 first when MSB-first, bit 0 first when LSB-first). N is word 0 bits 18:16, and values above 4 act as 4. Data byte n is taken from bits 8n+7:8n of the value last written to word 2.
- R6: One SCLK half period lasts P system cycles, where P is word 0 bits 31:24 and 0 acts as 1. SCLK idles at word 0 bit 0 and takes the opposite level during the second half of each bit. MOSI holds the bit for its whole bit time.
- R7: cs_n falls on the start edge, one half period before the first SCLK edge. It rises one half period after the last trailing SCLK edge.
- R8: With word 0 bit 1 at 0, MISO is captured at the leading SCLK edge of each data bit. With bit 1 at 1, it is captured at the trailing edge.
- R9: With word 0 bit 3 at 1, every capture happens one half period later than R8 gives. With bit 3 at 0 there is no delay.
- R10: When word 0 bit 4 is 0 and word 0 bit 0 equals word 0 bit 1, one extra sample is taken half a period before the first capture. That sample becomes received bit 0, and the captures of R8 and R9 follow it. Otherwise the received bits are the captures of R8 and R9 alone.
- R11: Received bit k lands in byte k/8 of word 2, at position k mod 8 (LSB-first) or 7 - k mod 8 (MSB-first). Bytes beyond N read 0. The word is cleared at start and holds its value while idle.
- R12: Word 1 keeps a mode byte in bits 31:24 and the dummy pattern in bits 23:0. Both reset to 0, and a write while idle reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register word select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| miso | input | 1 | Serial data from the flash |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the flash |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with the default divider width of 8 bits. It sets the half period at run time to between 1 and 4 cycles, with 0 also used, so the frame-length limits stay short enough to check every bit. These values bring the longest frame (24 dummy bits and 4 data bytes) within reach. They also cover the case where the doubly delayed trailing-edge capture coincides with the release of chip select, and the clamping of oversized dummy and byte counts. MISO changes every system cycle, so any capture taken one cycle or one half period away from the required moment shows up in the received word.

// File: rtl/spi_flash_master.sv
module spi_flash_master #(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        cs_n
);
  localparam int DUM_W  = 24;
  localparam int DATA_W = 32;
  localparam int HX_W   = 8;

  logic               cpol, rx_edge, msb_first, cap_dly, pre_off;
  logic [4:0]         dbits_q;
  logic [2:0]         nbytes_q;
  logic [DIV_W-1:0]   half_q, cnt, hlim;
  logic [7:0]         mode_q, cmd_q;
  logic [DUM_W-1:0]   dummy_q;
  logic [DATA_W-1:0]  tx_q, rx_q;
  logic               busy;
  logic [HX_W-1:0]    hidx, nh, last_h, s0;
  logic [5:0]         k;

  logic [4:0]         dcnt, di, ki, didx;
  logic [2:0]         nb;
  logic [6:0]         first_bit, nbits, bi;
  logic               adv, pre_on, take, start, wr_ok;

  assign dcnt      = (dbits_q > 5'd24) ? 5'd24 : dbits_q;
  assign nb        = (nbytes_q > 3'd4) ? 3'd4 : nbytes_q;
  assign hlim      = (half_q == '0) ? DIV_W'(1) : half_q;
  assign first_bit = 7'd8 + {2'b0, dcnt};
  assign nbits     = first_bit + {1'b0, nb, 3'b0};
  assign last_h    = {nbits, 1'b0};
  assign s0        = {first_bit, 1'b0} + 8'd1 + {7'b0, rx_edge} + {7'b0, cap_dly};
  assign nh        = hidx + 8'd1;
  assign adv       = busy && (cnt == hlim - DIV_W'(1));
  assign pre_on    = !pre_off && !(cpol ^ rx_edge);
  assign take      = adv && (k < {nb, 3'b0}) &&
                     ((pre_on && nh == s0 - 8'd1) || (nh >= s0 && nh[0] == s0[0]));
  assign start     = reg_wr && reg_addr == 2'd3 && reg_wdata[8] && !busy;
  assign wr_ok     = reg_wr && !busy;

  assign bi   = hidx[7:1];
  assign di   = bi[4:0] - 5'd8;
  assign ki   = bi[4:0] - 5'd8 - dcnt;
  assign didx = msb_first ? (dcnt - 5'd1 - di) : di;

  always_comb begin
    mosi = 1'b0;
    if (busy && hidx < last_h) begin
      if (bi < 7'd8)
        mosi = cmd_q[msb_first ? ~bi[2:0] : bi[2:0]];
      else if (bi < first_bit)
        mosi = dummy_q[didx];
      else
        mosi = tx_q[{ki[4:3], msb_first ? ~ki[2:0] : ki[2:0]}];
    end
  end

  assign sclk = cpol ^ (busy && hidx[0] && hidx < last_h);
  assign cs_n = !busy;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {8'(half_q), 5'b0, nbytes_q, 3'b0, dbits_q, 3'b0,
                            pre_off, cap_dly, msb_first, rx_edge, cpol};
      2'd1:    reg_rdata = {mode_q, dummy_q};
      2'd2:    reg_rdata = rx_q;
      default: reg_rdata = {31'b0, busy};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpol      <= 1'b0;
      rx_edge   <= 1'b0;
      msb_first <= 1'b1;
      cap_dly   <= 1'b0;
      pre_off   <= 1'b0;
      dbits_q   <= '0;
      nbytes_q  <= '0;
      half_q    <= '0;
      mode_q    <= '0;
      dummy_q   <= '0;
      tx_q      <= '0;
      cmd_q     <= '0;
      rx_q      <= '0;
      busy      <= 1'b0;
      cnt       <= '0;
      hidx      <= '0;
      k         <= '0;
    end else begin
      if (wr_ok) begin
        case (reg_addr)
          2'd0: begin
            cpol      <= reg_wdata[0];
            rx_edge   <= reg_wdata[1];
            msb_first <= reg_wdata[2];
            cap_dly   <= reg_wdata[3];
            pre_off   <= reg_wdata[4];
            dbits_q   <= reg_wdata[12:8];
            nbytes_q  <= reg_wdata[18:16];
            half_q    <= reg_wdata[24 +: DIV_W];
          end
          2'd1: begin
            mode_q  <= reg_wdata[31:24];
            dummy_q <= reg_wdata[23:0];
          end
          2'd2: tx_q <= reg_wdata;
          default: ;
        endcase
      end
      if (start) begin
        cmd_q <= reg_wdata[7:0];
        busy  <= 1'b1;
        cnt   <= '0;
        hidx  <= '0;
        k     <= '0;
        rx_q  <= '0;
      end else if (busy) begin
        if (adv) begin
          cnt  <= '0;
          hidx <= nh;
          if (nh == last_h + 8'd1) busy <= 1'b0;
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
        if (take) begin
          rx_q[{k[4:3], msb_first ? ~k[2:0] : k[2:0]}] <= miso;
          k <= k + 6'd1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_master_chk.sv
module spi_flash_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        cs_n,
  input logic        sclk,
  input logic        mosi,
  input logic        cpol,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic [7:0]  cmd_q,
  input logic [23:0] dummy_q,
  input logic [31:0] tx_q,
  input logic [31:0] rx_q,
  input logic [7:0]  hidx,
  input logic [7:0]  last_h
);
  a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wr && reg_addr == 2'd3 && reg_wdata[8] |=> $stable(cmd_q));

  a_r3_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(dummy_q) && $stable(tx_q));

  a_r7_cs_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> $past(hidx) == $past(last_h));

  a_r6_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) && $stable(cpol) |-> !cs_n);

  a_r5_mosi_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !mosi);

  a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && $past(!busy) |-> $stable(rx_q));
endmodule

bind spi_flash_master spi_flash_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
  .cpol(cpol), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .cmd_q(cmd_q), .dummy_q(dummy_q), .tx_q(tx_q), .rx_q(rx_q),
  .hidx(hidx), .last_h(last_h)
);

// File: tb/test_spi_flash_master.sv
module test_spi_flash_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic miso = 1'b0;
  logic sclk, mosi, cs_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_master i_spi_flash_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .miso(miso),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n));

  bit miso_arr [0:2047];
  bit mosi_log [0:2047];
  bit sclk_log [0:2047];
  bit csn_log  [0:2047];

  logic t_cpol, t_edge, t_msb, t_cap, t_preoff;
  logic [4:0] t_dbits;
  logic [2:0] t_nb;
  logic [7:0] t_half, t_cmd, t_mode;
  logic [23:0] t_dummy;
  logic [31:0] t_tx;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  function automatic int dc(); return (t_dbits > 24) ? 24 : int'(t_dbits); endfunction
  function automatic int nbc(); return (t_nb > 4) ? 4 : int'(t_nb); endfunction
  function automatic int hp(); return (t_half == 0) ? 1 : int'(t_half); endfunction
  function automatic int nbits(); return 8 + dc() + 8 * nbc(); endfunction

  function automatic bit exp_bit(int i);
    int j, p;
    if (i < 8) return t_msb ? t_cmd[7-i] : t_cmd[i];
    if (i < 8 + dc()) begin
      j = i - 8;
      return t_msb ? t_dummy[dc()-1-j] : t_dummy[j];
    end
    j = i - 8 - dc();
    p = j % 8;
    return t_tx[8*(j/8) + (t_msb ? 7-p : p)];
  endfunction

  function automatic logic [31:0] exp_rx();
    logic [31:0] r = '0;
    int s0, h, p;
    bit pre;
    s0  = 2*(8 + dc()) + 1 + int'(t_edge) + int'(t_cap);
    pre = !t_preoff && (t_cpol == t_edge);
    for (int k = 0; k < 8*nbc(); k++) begin
      if (pre) h = (k == 0) ? s0 - 1 : s0 + 2*(k-1);
      else     h = s0 + 2*k;
      p = k % 8;
      r[8*(k/8) + (t_msb ? 7-p : p)] = miso_arr[h*hp()];
    end
    return r;
  endfunction

  task automatic xfer();
    int tot, bad_sclk, bad_mosi, bad_cs;
    logic busy_mid, busy_end;
    logic [31:0] d;
    wr(2'd0, {t_half, 5'b0, t_nb, 3'b0, t_dbits, 3'b0, t_preoff, t_cap, t_msb, t_edge, t_cpol});
    wr(2'd1, {t_mode, t_dummy});
    wr(2'd2, t_tx);
    for (int i = 0; i < 2048; i++) miso_arr[i] = 1'($urandom);
    tot = (2*nbits() + 1) * hp();
    @(negedge clk);
    reg_addr = 2'd3; reg_wdata = {23'b0, 1'b1, t_cmd}; reg_wr = 1'b1; miso = miso_arr[0];
    @(negedge clk);
    busy_mid = 1'b0; busy_end = 1'b1;
    for (int m = 0; m <= tot; m++) begin
      mosi_log[m] = mosi; sclk_log[m] = sclk; csn_log[m] = cs_n;
      reg_wr = 1'b0; reg_addr = 2'd3;
      if (m == 2) begin reg_wr = 1'b1; reg_wdata = {23'b0, 1'b1, ~t_cmd}; end
      if (m == 3) begin reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = ~{t_mode, t_dummy}; end
      #1;
      if (m == 6)   busy_mid = reg_rdata[0];
      if (m == tot) busy_end = reg_rdata[0];
      miso = miso_arr[m+1];
      @(negedge clk);
    end
    reg_wr = 1'b0;
    bad_sclk = 0; bad_mosi = 0; bad_cs = 0;
    for (int i = 0; i < nbits(); i++) begin
      if (sclk_log[2*i*hp()] != t_cpol || sclk_log[(2*i+1)*hp()] != !t_cpol) bad_sclk++;
      if (mosi_log[2*i*hp()] != exp_bit(i) || mosi_log[(2*i+1)*hp()] != exp_bit(i)) bad_mosi++;
    end
    for (int m = 0; m < tot; m++) if (csn_log[m] != 1'b0) bad_cs++;
    if (csn_log[tot] != 1'b1) bad_cs++;
    if (sclk_log[2*nbits()*hp()] != t_cpol) bad_sclk++;
    check("R4/R5 mosi bit mismatches", bad_mosi, 0);
    check("R6 sclk level mismatches", bad_sclk, 0);
    check("R7 cs_n timing mismatches", bad_cs, 0);
    check("R2 busy mid/end", {busy_mid, busy_end}, 2'b10);
    rd(2'd1, d);
    check("R3 write while busy ignored", d, {t_mode, t_dummy});
    rd(2'd2, d);
    check("R8/R9/R10/R11 received word", d, exp_rx());
  endtask

  task automatic set(logic cp, logic ed, logic ms, logic ca, logic po,
                     logic [4:0] db, logic [2:0] nb, logic [7:0] hf);
    t_cpol = cp; t_edge = ed; t_msb = ms; t_cap = ca; t_preoff = po;
    t_dbits = db; t_nb = nb; t_half = hf;
    t_cmd = 8'($urandom); t_mode = 8'($urandom);
    t_dummy = 24'($urandom); t_tx = $urandom;
  endtask

  initial begin
    logic [31:0] d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 cs_n/sclk/mosi", {29'b0, cs_n, sclk, mosi}, 32'h4);
    rd(2'd0, d); check("R1 config word", d, 32'h4);
    rd(2'd1, d); check("R1 R12 mode/dummy reset", d, 32'h0);
    rd(2'd3, d); check("R1 status", d, 32'h0);
    wr(2'd1, 32'hA5C3_0F96);
    rd(2'd1, d); check("R12 mode/dummy readback", d, 32'hA5C3_0F96);

    set(0,0,1,0,1, 5'd0,  3'd2, 8'd1); xfer();   // basic MSB-first
    set(0,0,0,0,1, 5'd0,  3'd2, 8'd2); xfer();   // R4 LSB-first
    set(0,0,1,0,1, 5'd24, 3'd1, 8'd1); xfer();   // R5 full dummy
    set(0,0,0,0,1, 5'd13, 3'd1, 8'd1); xfer();   // R5 dummy LSB-first
    set(0,0,1,0,0, 5'd0,  3'd2, 8'd1); xfer();   // R10 early sample
    set(1,1,1,0,0, 5'd3,  3'd2, 8'd2); xfer();   // R10 polarity 1, trailing
    set(1,0,1,0,0, 5'd0,  3'd2, 8'd1); xfer();   // R10 mismatch: no early sample
    set(0,1,1,1,1, 5'd0,  3'd4, 8'd1); xfer();   // R8 R9 last capture at release
    set(0,0,1,1,1, 5'd0,  3'd1, 8'd3); xfer();   // R9 delay on leading edge
    set(1,0,1,1,0, 5'd31, 3'd7, 8'd0); xfer();   // R5 R6 clamps, zero divider
    set(0,0,1,0,0, 5'd5,  3'd0, 8'd1); xfer();   // R11 no data bytes
    for (int r = 0; r < 20; r++) begin
      set(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
          5'($urandom_range(0, 26)), 3'($urandom_range(0, 5)), 8'($urandom_range(0, 4)));
      xfer();
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule